// File: doc/BRIEF.md
# Dual-Slot CPU Clock Setting Sequencer

This block moves a CPU clock to a new setting without touching the setting that is driving the CPU at that moment. It keeps two source slots in a control register. Each slot holds a source select and a source divider. A select register names the live slot and also holds the bus clock divider. On a request, the block loads a wait-state count. It writes the new select and then the new divider into the slot that is not live, as two separate steps. It then flips the live-slot bit, so the clock multiplexer downstream changes over in a single step.

The bus divider is written on whichever side of the flip keeps the bus clock slow enough. A larger divider goes in before the flip and a smaller one after it. An unchanged divider is not written at all. Each field write takes one cycle. When the last write is done, a one-cycle done pulse follows. A read-only pair of outputs always shows the select and divider of the live slot, which also decodes whatever state the registers came out of reset in.

Top module: `clksel_sequencer`

## Requirements
- R1: After reset the control register equals RST_CTRL (default 0), the select register equals RST_SEL (default 0), and busy and done are low.
- R2: Control register layout: slot 1 divider in bits 3:0, slot 1 select in bits 6:4, slot 0 divider in bits 11:8, slot 0 select in bits 14:12, wait count in bits 23:16. Select register layout: bit 0 is the live slot (0 = slot 0, 1 = slot 1) and bits 2:1 are the bus divider.
- R3: With slot 0 live, a request writes the slot 1 fields and then sets bit 0. The slot 0 fields do not change during the request.
- R4: With slot 1 live, a request writes the slot 0 fields and then clears bit 0. The slot 1 fields do not change during the request.
- R5: A requested bus divider greater than the current one is written in an earlier cycle than the slot flip.
- R6: A requested bus divider smaller than the current one is written in a later cycle than the slot flip.
- R7: A requested bus divider equal to the current one is never written, and the request takes one cycle less.
- R8: The idle slot's select field changes in an earlier cycle than its divider field.
- R9: The wait field holds WAIT_CNT (default 100) before the slot flip, and it is written first, one cycle after the request is accepted.
- R10: done is high for exactly one cycle. It rises 5 cycles after the accepting edge when the bus divider changes and 4 cycles after when it does not. During the done cycle busy is low.
- R11: busy is high from the cycle after acceptance until the final write. A request raised while busy is ignored and changes no register.
- R12: act_src and act_div show the select and divider of the slot named by select-register bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a change; taken only while idle |
| req_src | input | 3 | New source select |
| req_div | input | 4 | New source divider |
| req_bus | input | 2 | New bus divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ctrl_reg | output | CTRL_W | Control register contents |
| sel_reg | output | SEL_W | Select register contents |
| act_src | output | 3 | Source select of the live slot |
| act_div | output | 4 | Divider of the live slot |

## Verification
A sweep of 64 requests walks every source select and many dividers. It starts from both live slots in turn, so each request exercises the slot 0 to 1 flip or its reverse. The bus divider sequence rises, falls and repeats, which separates the before-flip order, the after-flip order and the skipped write. These cases are told apart by the cycle in which each register field first changes and by the done latency. Every other request keeps req_valid high with inverted values while busy, which shows whether a busy-time request leaks into the registers.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int SRC_W  = 3;
  localparam int DIV_W  = 4;
  localparam int BUS_W  = 2;
  localparam int WAIT_W = 8;
  localparam int SLOT_W = SRC_W + DIV_W;

  // Field positions decoded by the downstream clock multiplexer.
  localparam int S1_DIV_LSB   = 0;
  localparam int S1_SRC_LSB   = 4;
  localparam int S0_DIV_LSB   = 8;
  localparam int S0_SRC_LSB   = 12;
  localparam int WAIT_LSB     = 16;
  localparam int SEL_SLOT_BIT = 0;
  localparam int SEL_BUS_LSB  = 1;

  typedef enum logic [2:0] {
    OP_NONE, OP_WAIT, OP_BUS, OP_SRC, OP_DIV, OP_FLIP
  } wr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_BUS_PRE, ST_SRC, ST_DIV, ST_FLIP, ST_BUS_POST
  } seq_st_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
    logic [BUS_W-1:0] bus;
  } clk_req_t;
endpackage

// File: rtl/clksel_seq.sv
module clksel_seq
  import clksel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  clk_req_t         req,
  input  logic [BUS_W-1:0] cur_bus,
  output logic             busy,
  output logic             done,
  output wr_op_e           wr_op,
  output clk_req_t         wr_data
);
  seq_st_e  st;
  clk_req_t hold;
  logic     bus_up, bus_dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      hold   <= '0;
      bus_up <= 1'b0;
      bus_dn <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          hold   <= req;
          bus_up <= (req.bus > cur_bus);
          bus_dn <= (req.bus < cur_bus);
          st     <= ST_WAIT;
        end
        ST_WAIT:    st <= bus_up ? ST_BUS_PRE : ST_SRC;
        ST_BUS_PRE: st <= ST_SRC;
        ST_SRC:     st <= ST_DIV;
        ST_DIV:     st <= ST_FLIP;
        ST_FLIP: begin
          if (bus_dn) st <= ST_BUS_POST;
          else begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        ST_BUS_POST: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_WAIT:     wr_op = OP_WAIT;
      ST_BUS_PRE:  wr_op = OP_BUS;
      ST_SRC:      wr_op = OP_SRC;
      ST_DIV:      wr_op = OP_DIV;
      ST_FLIP:     wr_op = OP_FLIP;
      ST_BUS_POST: wr_op = OP_BUS;
      default:     wr_op = OP_NONE;
    endcase
  end

  assign busy    = (st != ST_IDLE);
  assign wr_data = hold;
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int                CTRL_W   = 32,
  parameter int                SEL_W    = 3,
  parameter int                WAIT_CNT = 100,
  parameter logic [CTRL_W-1:0] RST_CTRL = '0,
  parameter logic [SEL_W-1:0]  RST_SEL  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_op_e            wr_op,
  input  clk_req_t          wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [SEL_W-1:0]  sel_q
);
  localparam logic [WAIT_W-1:0] WAIT_VAL = WAIT_CNT[WAIT_W-1:0];

  logic live;
  assign live = sel_q[SEL_SLOT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RST_CTRL;
      sel_q  <= RST_SEL;
    end else begin
      case (wr_op)
        OP_WAIT: ctrl_q[WAIT_LSB +: WAIT_W] <= WAIT_VAL;
        OP_BUS:  sel_q[SEL_BUS_LSB +: BUS_W] <= wr_data.bus;
        OP_SRC: begin
          if (live) ctrl_q[S0_SRC_LSB +: SRC_W] <= wr_data.src;
          else      ctrl_q[S1_SRC_LSB +: SRC_W] <= wr_data.src;
        end
        OP_DIV: begin
          if (live) ctrl_q[S0_DIV_LSB +: DIV_W] <= wr_data.div;
          else      ctrl_q[S1_DIV_LSB +: DIV_W] <= wr_data.div;
        end
        OP_FLIP: sel_q[SEL_SLOT_BIT] <= ~live;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clksel_view.sv
module clksel_view
  import clksel_pkg::*;
(
  input  logic             slot_bit,
  input  logic [SRC_W-1:0] s0_src,
  input  logic [DIV_W-1:0] s0_div,
  input  logic [SRC_W-1:0] s1_src,
  input  logic [DIV_W-1:0] s1_div,
  output logic [SRC_W-1:0] act_src,
  output logic [DIV_W-1:0] act_div
);
  assign act_src = slot_bit ? s1_src : s0_src;
  assign act_div = slot_bit ? s1_div : s0_div;
endmodule

// File: rtl/clksel_sequencer.sv
module clksel_sequencer
  import clksel_pkg::*;
#(
  parameter int                CTRL_W   = 32,
  parameter int                SEL_W    = 3,
  parameter int                WAIT_CNT = 100,
  parameter logic [CTRL_W-1:0] RST_CTRL = '0,
  parameter logic [SEL_W-1:0]  RST_SEL  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_src,
  input  logic [3:0]        req_div,
  input  logic [1:0]        req_bus,
  output logic              busy,
  output logic              done,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [SEL_W-1:0]  sel_reg,
  output logic [2:0]        act_src,
  output logic [3:0]        act_div
);
  clk_req_t req, wr_data;
  wr_op_e   wr_op;

  assign req = '{src: req_src, div: req_div, bus: req_bus};

  clksel_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req(req),
    .cur_bus(sel_reg[SEL_BUS_LSB +: BUS_W]),
    .busy(busy), .done(done), .wr_op(wr_op), .wr_data(wr_data)
  );

  clksel_regs #(
    .CTRL_W(CTRL_W), .SEL_W(SEL_W), .WAIT_CNT(WAIT_CNT),
    .RST_CTRL(RST_CTRL), .RST_SEL(RST_SEL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_op(wr_op), .wr_data(wr_data),
    .ctrl_q(ctrl_reg), .sel_q(sel_reg)
  );

  clksel_view u_view (
    .slot_bit(sel_reg[SEL_SLOT_BIT]),
    .s0_src(ctrl_reg[S0_SRC_LSB +: SRC_W]),
    .s0_div(ctrl_reg[S0_DIV_LSB +: DIV_W]),
    .s1_src(ctrl_reg[S1_SRC_LSB +: SRC_W]),
    .s1_div(ctrl_reg[S1_DIV_LSB +: DIV_W]),
    .act_src(act_src), .act_div(act_div)
  );
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
  import clksel_pkg::*;
#(
  parameter int WAIT_CNT = 100
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              slot_bit,
  input logic [SLOT_W-1:0] s0_fields,
  input logic [SLOT_W-1:0] s1_fields,
  input logic [WAIT_W-1:0] wait_f,
  input logic [BUS_W-1:0]  bus_f
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R10
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(s0_fields) && $stable(s1_fields) && $stable(slot_bit)
               && $stable(bus_f) && $stable(wait_f)));  // R11
  AST_SLOT0_HELD: assert property (@(posedge clk) disable iff (rst)
    !slot_bit |=> (slot_bit || $stable(s0_fields)));  // R3
  AST_SLOT1_HELD: assert property (@(posedge clk) disable iff (rst)
    slot_bit |=> (!slot_bit || $stable(s1_fields)));  // R4
  AST_WAIT_AT_FLIP: assert property (@(posedge clk) disable iff (rst)
    (slot_bit != $past(slot_bit)) |-> (wait_f == WAIT_CNT[WAIT_W-1:0]));  // R9
endmodule

bind clksel_sequencer clksel_chk #(.WAIT_CNT(WAIT_CNT)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .slot_bit(sel_reg[clksel_pkg::SEL_SLOT_BIT]),
  .s0_fields(ctrl_reg[clksel_pkg::S0_DIV_LSB +: clksel_pkg::SLOT_W]),
  .s1_fields(ctrl_reg[clksel_pkg::S1_DIV_LSB +: clksel_pkg::SLOT_W]),
  .wait_f(ctrl_reg[clksel_pkg::WAIT_LSB +: clksel_pkg::WAIT_W]),
  .bus_f(sel_reg[clksel_pkg::SEL_BUS_LSB +: clksel_pkg::BUS_W])
);

// File: tb/tb_clksel_sequencer.sv
`timescale 1ns/1ps
module tb_clksel_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_src = '0;
  logic [3:0]  req_div = '0;
  logic [1:0]  req_bus = '0;
  logic        busy, done;
  logic [31:0] ctrl_reg;
  logic [2:0]  sel_reg;
  logic [2:0]  act_src;
  logic [3:0]  act_div;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clksel_sequencer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_div(req_div), .req_bus(req_bus), .busy(busy), .done(done),
    .ctrl_reg(ctrl_reg), .sel_reg(sel_reg), .act_src(act_src), .act_div(act_div)
  );

  function automatic int f_src(int slot);
    return (slot != 0) ? int'(ctrl_reg[6:4]) : int'(ctrl_reg[14:12]);
  endfunction
  function automatic int f_div(int slot);
    return (slot != 0) ? int'(ctrl_reg[3:0]) : int'(ctrl_reg[11:8]);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_req(input int src, input int div, input int bus, input bit noisy);
    int o_slot, n_slot, o_bus, o_isrc, o_idiv, o_asrc, o_adiv;
    int fw, fb, fs, fd, ff, kd, exp_k;
    bit held_ok;
    string rs;
    o_slot = int'(sel_reg[0]);
    n_slot = 1 - o_slot;
    o_bus  = int'(sel_reg[2:1]);
    o_isrc = f_src(n_slot);
    o_idiv = f_div(n_slot);
    o_asrc = f_src(o_slot);
    o_adiv = f_div(o_slot);
    fw = 0; fb = 0; fs = 0; fd = 0; ff = 0; kd = 0;
    held_ok = 1'b1;
    rs = (o_slot == 0) ? "R3" : "R4";
    req_valid = 1'b1;
    req_src = 3'(src); req_div = 4'(div); req_bus = 2'(bus);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
      if (noisy && k <= 2) begin
        req_valid = 1'b1;
        req_src = ~3'(src); req_div = ~4'(div); req_bus = ~2'(bus);
      end else req_valid = 1'b0;
      if (fw == 0 && ctrl_reg[23:16] != 8'd0 && k > 1 && fw == 0) fw = k;
      if (fb == 0 && int'(sel_reg[2:1]) != o_bus) fb = k;
      if (fs == 0 && f_src(n_slot) != o_isrc) fs = k;
      if (fd == 0 && f_div(n_slot) != o_idiv) fd = k;
      if (ff == 0 && int'(sel_reg[0]) != o_slot) ff = k;
      if (f_src(o_slot) != o_asrc || f_div(o_slot) != o_adiv) held_ok = 1'b0;
      if (done) begin kd = k; break; end
    end
    exp_k = (bus != o_bus) ? 6 : 5;
    chk(kd == exp_k, "R10 done latency", kd, exp_k);
    chk(held_ok, {rs, " live slot fields untouched"}, int'(held_ok), 1);
    chk(ff > 0 && int'(sel_reg[0]) == n_slot, {rs, " slot bit flipped"}, int'(sel_reg[0]), n_slot);
    chk(int'(ctrl_reg[23:16]) == 100, "R9 wait count loaded", int'(ctrl_reg[23:16]), 100);
    if (fd > 0) chk(fd < ff, {rs, " divider before flip"}, fd, ff - 1);
    if (fs > 0 && fd > 0) chk(fs < fd, "R8 select before divider", fs, fd - 1);
    if (bus > o_bus) chk(fb > 0 && fb < ff, "R5 larger bus divider before flip", fb, ff - 1);
    else if (bus < o_bus) chk(fb > ff, "R6 smaller bus divider after flip", fb, ff + 1);
    else chk(fb == 0, "R7 equal bus divider not written", fb, 0);
    chk(f_src(n_slot) == src && f_div(n_slot) == div && int'(sel_reg[2:1]) == bus,
        noisy ? "R11 busy request ignored, R2 fields" : "R2 final fields",
        f_src(n_slot) * 256 + f_div(n_slot) * 4 + int'(sel_reg[2:1]), src * 256 + div * 4 + bus);
    chk(int'(act_src) == src && int'(act_div) == div, "R12 live readback",
        int'(act_src) * 16 + int'(act_div), src * 16 + div);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 done single cycle, idle", int'(done) * 2 + int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ctrl_reg == 32'd0 && sel_reg == 3'd0, "R1 reset registers", int'(ctrl_reg[15:0]), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'(busy) * 2 + int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && act_src == 3'd0 && act_div == 4'd0, "R12 reset decode",
        int'(act_src) * 16 + int'(act_div), 0);
    chk(ctrl_reg[23:16] == 8'd0, "R9 wait field untouched when idle", int'(ctrl_reg[23:16]), 0);
    for (int i = 0; i < 64; i++) begin
      int b;
      b = (i < 32) ? ((i >> 1) & 3) : ((i * 3) & 3);
      do_req(i % 8, (i * 5 + 3) % 16, b, i[0]);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule